// File: doc/BRIEF.md
# Wiper Register Command Controller

This block is the command layer of a digitally set potentiometer. It sits behind a two-wire serial byte engine. That engine handles START, the device address and acknowledges, and it hands this block a stream of bytes. The first byte of each command is the instruction byte, marked by a first-byte strobe and accompanied by the read/write flag taken from the address byte. The block decodes the opcode together with that flag and acts on two kinds of storage. One is a volatile wiper register, whose 10-bit value sets the wiper position. The others are four 10-bit data registers that model nonvolatile storage.

Every change of state waits for the STOP strobe. A store into a data register then holds `busy` high for a programmable number of clocks, which models the slow nonvolatile write cycle. Loads into the wiper register take effect at once and never raise `busy`. A write-protect input can suppress data-register stores. After reset the wiper register is loaded from data register 0.

Incoming bytes use a valid/ready handshake. `in_ready` is low during the one-cycle recall after reset and for the whole busy interval. The byte engine must hold a byte until it is accepted, or refuse it on the bus. Read data leaves on a second valid/ready channel. While `out_valid` is high and `out_ready` is low, `out_byte` is held.

Top module: `wpr_cmd_ctrl`

## Requirements
- R1: The instruction byte carries the opcode in bits 7:5 and the register select in bits 3:2 (00 to 11 selects data register 0 to 3). Bit 4 and bits 1:0 must be zero.
- R2: During reset the wiper output is 0, and `in_ready`, `out_valid` and `busy` are low. On the first clock edge after reset is released, the wiper takes the reset content of data register 0 (parameter `DR_INIT`, register n at bits n*10+9:n*10), and `in_ready` rises.
- R3: Write wiper (flag 0, opcode 101) takes two data bytes. Byte one supplies position bits 9:8 in its bits 1:0, and byte two supplies bits 7:0. The wiper output changes on the edge that samples STOP, and `busy` stays low.
- R4: Read wiper (flag 1, opcode 100) and read data register (flag 1, opcode 101) send two bytes on the output channel: first {000000, value[9:8]}, then value[7:0]. A byte that is not accepted keeps `out_valid` high and `out_byte` unchanged.
- R5: Write data register (flag 0, opcode 110) stores the two-byte value into the selected register at STOP. `busy` is then high for exactly `BUSY_CYCLES` cycles, starting right after that edge.
- R6: Transfer data register to wiper (flag 1, opcode 110) loads the wiper at STOP without raising `busy`. Transfer wiper to data register (flag 0, opcode 111) stores the wiper at STOP and raises `busy` as in R5. Neither transfer carries data bytes.
- R7: If `wp_n` is low when STOP is sampled, a data-register write or transfer leaves all data registers unchanged and does not raise `busy`. Wiper loads are not affected by `wp_n`.
- R8: A write command ended by STOP before both data bytes have arrived changes no register and does not raise `busy`.
- R9: A flag/opcode pair outside the six commands, or an instruction byte with a nonzero reserved bit, is ignored. Its bytes are accepted and dropped, and nothing changes at STOP.
- R10: While `busy` is high, `in_ready` is low, and a byte offered then has no effect.
- R11: The wiper output changes only on the recall edge after reset or on an edge that samples STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| in_valid | input | 1 | Incoming byte is valid |
| in_ready | output | 1 | Block accepts the incoming byte |
| in_byte | input | 8 | Incoming byte |
| in_first | input | 1 | Byte is the instruction byte (first after address) |
| in_rd | input | 1 | Read/write flag from the address byte, sampled with `in_first` |
| bus_stop | input | 1 | One-cycle STOP strobe; it takes priority over a byte in the same cycle |
| out_valid | output | 1 | Read byte is valid |
| out_ready | input | 1 | Byte engine takes the read byte |
| out_byte | output | 8 | Read byte |
| wp_n | input | 1 | Low suppresses data-register stores |
| busy | output | 1 | Nonvolatile store cycle in progress |
| wiper_pos | output | 10 | Wiper position: 0 is the low terminal, 3FF hex the high terminal |

## Verification
The checker watches four things on every cycle:
- the wiper value never moves outside a STOP edge or the recall edge;
- `in_ready` is low whenever `busy` is high;
- a stalled read byte holds steady;
- `busy` rises only after STOP, is never raised when write protection is active, and lasts exactly the programmed number of cycles.

Only the bench scenarios can show the command semantics. These cover the opcode and flag decoding, the register selected, the values that reach the registers, the read byte layout, write protection leaving stored data intact, and truncated or undefined commands leaving everything unchanged. Each of these is shown by reading the registers back through the normal command interface.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  localparam int unsigned NREG    = 4;
  localparam int unsigned SEL_W   = $clog2(NREG);
  localparam int unsigned OP_LSB  = 5;
  localparam int unsigned SEL_LSB = 2;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_RD_WIPER,
    CMD_WR_WIPER,
    CMD_RD_DREG,
    CMD_WR_DREG,
    CMD_DREG_TO_WIPER,
    CMD_WIPER_TO_DREG
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GET_HI,
    ST_GET_LO,
    ST_SEND_HI,
    ST_SEND_LO,
    ST_WAIT_STOP
  } state_e;
endpackage

// File: rtl/wpr_cmd_decode.sv
module wpr_cmd_decode
  import wpr_pkg::*;
(
  input  logic [7:0]       instr,
  input  logic             rd,
  output cmd_e             cmd,
  output logic [SEL_W-1:0] sel
);
  logic [2:0] op;
  logic       resv_ok;

  always_comb begin
    op      = instr[OP_LSB +: 3];
    sel     = instr[SEL_LSB +: SEL_W];
    resv_ok = (instr[4] == 1'b0) && (instr[1:0] == 2'b00);
    cmd     = CMD_NONE;
    if (resv_ok) begin
      unique case ({rd, op})
        4'b1100: cmd = CMD_RD_WIPER;
        4'b0101: cmd = CMD_WR_WIPER;
        4'b1101: cmd = CMD_RD_DREG;
        4'b0110: cmd = CMD_WR_DREG;
        4'b1110: cmd = CMD_DREG_TO_WIPER;
        4'b0111: cmd = CMD_WIPER_TO_DREG;
        default: cmd = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/wpr_busy_timer.sv
module wpr_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= CW'(BUSY_CYCLES);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/wpr_reg_bank.sv
module wpr_reg_bank
  import wpr_pkg::*;
#(
  parameter int unsigned             POS_W   = 10,
  parameter logic [NREG*POS_W-1:0]   DR_INIT = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dr_we,
  input  logic [SEL_W-1:0]         dr_sel,
  input  logic [POS_W-1:0]         dr_wdata,
  input  logic                     wip_we,
  input  logic [POS_W-1:0]         wip_wdata,
  output logic [NREG*POS_W-1:0]    dr_flat,
  output logic [POS_W-1:0]         wiper,
  output logic                     recall_act
);
  logic [POS_W-1:0] dr_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_dreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             dr_q[g] <= DR_INIT[g*POS_W +: POS_W];
      else if (dr_we && dr_sel == SEL_W'(g))  dr_q[g] <= dr_wdata;
    end
    assign dr_flat[g*POS_W +: POS_W] = dr_q[g];
  end

  // One recall cycle after reset copies register 0 into the wiper.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recall_act <= 1'b1;
      wiper      <= '0;
    end else begin
      recall_act <= 1'b0;
      if (recall_act)  wiper <= dr_q[0];
      else if (wip_we) wiper <= wip_wdata;
    end
  end
endmodule

// File: rtl/wpr_cmd_ctrl.sv
module wpr_cmd_ctrl
  import wpr_pkg::*;
#(
  parameter int unsigned           POS_W       = 10,
  parameter int unsigned           BUSY_CYCLES = 500000,
  parameter logic [NREG*POS_W-1:0] DR_INIT     = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  input  logic             in_first,
  input  logic             in_rd,
  input  logic             bus_stop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_byte,
  input  logic             wp_n,
  output logic             busy,
  output logic [POS_W-1:0] wiper_pos
);
  localparam int unsigned HI_W = POS_W - 8;

  state_e             state_q;
  cmd_e               cmd_q, dec_cmd;
  logic [SEL_W-1:0]   sel_q, dec_sel;
  logic [HI_W-1:0]    hi_q;
  logic [POS_W-1:0]   pos_q, tx_val_q;
  logic               pend_q;

  logic [NREG*POS_W-1:0] dr_flat;
  logic [POS_W-1:0]   wiper_q, dr_at_dec, dr_at_sel, dr_wdata, wip_wdata;
  logic               recall_act, busy_int;
  logic               in_acc, out_acc, commit, dr_we, wip_we;

  wpr_cmd_decode u_dec (
    .instr (in_byte),
    .rd    (in_rd),
    .cmd   (dec_cmd),
    .sel   (dec_sel)
  );

  assign in_ready  = !busy_int && !recall_act;
  assign in_acc    = in_valid && in_ready;
  assign out_valid = (state_q == ST_SEND_HI) || (state_q == ST_SEND_LO);
  assign out_acc   = out_valid && out_ready;
  assign out_byte  = (state_q == ST_SEND_HI)
                   ? {{(8-HI_W){1'b0}}, tx_val_q[POS_W-1:8]}
                   : tx_val_q[7:0];

  assign dr_at_dec = dr_flat[dec_sel*POS_W +: POS_W];
  assign dr_at_sel = dr_flat[sel_q*POS_W +: POS_W];

  // Every register change is committed on the STOP edge.
  assign commit    = bus_stop && pend_q;
  assign wip_we    = commit && (cmd_q == CMD_WR_WIPER || cmd_q == CMD_DREG_TO_WIPER);
  assign wip_wdata = (cmd_q == CMD_WR_WIPER) ? pos_q : dr_at_sel;
  assign dr_we     = commit && wp_n && (cmd_q == CMD_WR_DREG || cmd_q == CMD_WIPER_TO_DREG);
  assign dr_wdata  = (cmd_q == CMD_WR_DREG) ? pos_q : wiper_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cmd_q    <= CMD_NONE;
      sel_q    <= '0;
      hi_q     <= '0;
      pos_q    <= '0;
      tx_val_q <= '0;
      pend_q   <= 1'b0;
    end else if (bus_stop) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else if (in_acc && in_first) begin
      cmd_q  <= dec_cmd;
      sel_q  <= dec_sel;
      pend_q <= 1'b0;
      unique case (dec_cmd)
        CMD_RD_WIPER: begin
          tx_val_q <= wiper_q;
          state_q  <= ST_SEND_HI;
        end
        CMD_RD_DREG: begin
          tx_val_q <= dr_at_dec;
          state_q  <= ST_SEND_HI;
        end
        CMD_WR_WIPER, CMD_WR_DREG: state_q <= ST_GET_HI;
        CMD_DREG_TO_WIPER, CMD_WIPER_TO_DREG: begin
          pend_q  <= 1'b1;
          state_q <= ST_WAIT_STOP;
        end
        default: state_q <= ST_WAIT_STOP;
      endcase
    end else begin
      unique case (state_q)
        ST_GET_HI: if (in_acc) begin
          hi_q    <= in_byte[HI_W-1:0];
          state_q <= ST_GET_LO;
        end
        ST_GET_LO: if (in_acc) begin
          pos_q   <= {hi_q, in_byte};
          pend_q  <= 1'b1;
          state_q <= ST_WAIT_STOP;
        end
        ST_SEND_HI: if (out_acc) state_q <= ST_SEND_LO;
        ST_SEND_LO: if (out_acc) state_q <= ST_WAIT_STOP;
        default: ;
      endcase
    end
  end

  wpr_reg_bank #(
    .POS_W   (POS_W),
    .DR_INIT (DR_INIT)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .dr_we      (dr_we),
    .dr_sel     (sel_q),
    .dr_wdata   (dr_wdata),
    .wip_we     (wip_we),
    .wip_wdata  (wip_wdata),
    .dr_flat    (dr_flat),
    .wiper      (wiper_q),
    .recall_act (recall_act)
  );

  wpr_busy_timer #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (dr_we),
    .busy  (busy_int)
  );

  assign busy      = busy_int;
  assign wiper_pos = wiper_q;
endmodule

// File: rtl/wpr_cmd_ctrl_chk.sv
module wpr_cmd_ctrl_chk #(
  parameter int unsigned POS_W       = 10,
  parameter int unsigned BUSY_CYCLES = 500000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_first,
  input logic             in_ready,
  input logic             bus_stop,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_byte,
  input logic             wp_n,
  input logic             busy,
  input logic [POS_W-1:0] wiper_pos,
  input logic             recall_act
);
  localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] busy_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run_q <= '0;
    else if (busy) busy_run_q <= busy_run_q + 1'b1;
    else           busy_run_q <= '0;
  end

  a_r11_wiper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_stop && !recall_act) |=> $stable(wiper_pos));

  a_r10_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !bus_stop && !(in_valid && in_first))
      |=> (out_valid && $stable(out_byte)));

  a_r5_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop));

  a_r5_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run_q < CW'(BUSY_CYCLES)));

  a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run_q == CW'(BUSY_CYCLES)));

  a_r7_wp_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && bus_stop && !busy) |=> !busy);
endmodule

bind wpr_cmd_ctrl wpr_cmd_ctrl_chk #(
  .POS_W       (POS_W),
  .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_first   (in_first),
  .in_ready   (in_ready),
  .bus_stop   (bus_stop),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_byte   (out_byte),
  .wp_n       (wp_n),
  .busy       (busy),
  .wiper_pos  (wiper_pos),
  .recall_act (recall_act)
);

// File: tb/wpr_cmd_ctrl_tb.sv
module wpr_cmd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_N     = 20;
  localparam logic [39:0] INIT = {10'h000, 10'h0F0, 10'h0AA, 10'h200};

  logic       clk = 0, rst_n = 0;
  logic       in_valid = 0, in_first = 0, in_rd = 0, bus_stop = 0;
  logic [7:0] in_byte = 0;
  logic       out_ready = 0, wp_n = 1;
  logic       in_ready, out_valid, busy;
  logic [7:0] out_byte;
  logic [9:0] wiper_pos;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpr_cmd_ctrl #(.POS_W(10), .BUSY_CYCLES(BUSY_N), .DR_INIT(INIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_first(in_first), .in_rd(in_rd), .bus_stop(bus_stop),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .wp_n(wp_n), .busy(busy), .wiper_pos(wiper_pos));

  typedef struct packed {
    logic       rd;
    logic [7:0] ins;
    logic [9:0] dat;
    logic [1:0] nd;
    logic       wp;
    logic       chk_rd;
    logic [9:0] exp_rd;
    logic [9:0] exp_wip;
    logic       exp_busy;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h80, 10'h000, 2'd0, 1'b1, 1'b1, 10'h200, 10'h200, 1'b0}, // R4 read wiper after recall
    '{1'b0, 8'hA0, 10'h3FF, 2'd2, 1'b1, 1'b0, 10'h000, 10'h3FF, 1'b0}, // R3 write wiper
    '{1'b1, 8'h80, 10'h000, 2'd0, 1'b1, 1'b1, 10'h3FF, 10'h3FF, 1'b0}, // R4
    '{1'b0, 8'hC4, 10'h123, 2'd2, 1'b1, 1'b0, 10'h000, 10'h3FF, 1'b1}, // R5 write reg 1
    '{1'b1, 8'hA4, 10'h000, 2'd0, 1'b1, 1'b1, 10'h123, 10'h3FF, 1'b0}, // R1 select reg 1
    '{1'b1, 8'hC8, 10'h000, 2'd0, 1'b1, 1'b0, 10'h000, 10'h0F0, 1'b0}, // R6 reg 2 to wiper
    '{1'b0, 8'hEC, 10'h000, 2'd0, 1'b1, 1'b0, 10'h000, 10'h0F0, 1'b1}, // R6 wiper to reg 3
    '{1'b1, 8'hAC, 10'h000, 2'd0, 1'b1, 1'b1, 10'h0F0, 10'h0F0, 1'b0}, // R6 read reg 3
    '{1'b0, 8'hA0, 10'h000, 2'd2, 1'b1, 1'b0, 10'h000, 10'h000, 1'b0}, // R3 low end
    '{1'b0, 8'hE0, 10'h000, 2'd0, 1'b0, 1'b0, 10'h000, 10'h000, 1'b0}, // R7 protected transfer
    '{1'b1, 8'hA0, 10'h000, 2'd0, 1'b1, 1'b1, 10'h200, 10'h000, 1'b0}, // R7 reg 0 kept
    '{1'b0, 8'hC8, 10'h2AA, 2'd2, 1'b0, 1'b0, 10'h000, 10'h000, 1'b0}, // R7 protected write
    '{1'b1, 8'hA8, 10'h000, 2'd0, 1'b1, 1'b1, 10'h0F0, 10'h000, 1'b0}, // R7 reg 2 kept
    '{1'b1, 8'hCC, 10'h000, 2'd0, 1'b1, 1'b0, 10'h000, 10'h0F0, 1'b0}, // R6 reg 3 to wiper
    '{1'b0, 8'h80, 10'h155, 2'd2, 1'b1, 1'b0, 10'h000, 10'h0F0, 1'b0}, // R9 flag 0 op 100
    '{1'b1, 8'hE0, 10'h000, 2'd0, 1'b1, 1'b0, 10'h000, 10'h0F0, 1'b0}, // R9 flag 1 op 111
    '{1'b0, 8'hB0, 10'h155, 2'd2, 1'b1, 1'b0, 10'h000, 10'h0F0, 1'b0}, // R9 reserved bit 4
    '{1'b0, 8'hA0, 10'h001, 2'd2, 1'b0, 1'b0, 10'h000, 10'h001, 1'b0}  // R7 wiper ignores wp_n
  };

  function automatic string vreq(int i);
    case (i)
      1, 8:              return "R3";
      0, 2:              return "R4";
      3:                 return "R5";
      4:                 return "R1";
      5, 6, 7, 13:       return "R6";
      9, 10, 11, 12, 17: return "R7";
      default:           return "R9";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic first, input logic rd);
    @(negedge clk);
    in_valid = 1; in_byte = b; in_first = first; in_rd = rd;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_first = 0;
  endtask

  task automatic send_stop();
    @(negedge clk); bus_stop = 1;
    @(negedge clk); bus_stop = 0;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    @(negedge clk); out_ready = 1;
    while (!out_valid) @(negedge clk);
    b = out_byte;
    @(negedge clk); out_ready = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] b0, b1;
    int cnt;
    // R2 reset state
    repeat (3) @(negedge clk);
    check("R2", wiper_pos, 0);
    check("R2", in_ready, 0);
    check("R2", out_valid, 0);
    check("R2", busy, 0);
    rst_n = 1;
    @(negedge clk);
    check("R2", wiper_pos, 10'h200);
    check("R2", in_ready, 1);

    for (int i = 0; i < NV; i++) begin
      wp_n = VECS[i].wp;
      send_byte(VECS[i].ins, 1'b1, VECS[i].rd);
      if (VECS[i].chk_rd) begin
        recv_byte(b0);
        recv_byte(b1);
        check(vreq(i), {b0, b1}, {6'b0, VECS[i].exp_rd});
      end
      if (VECS[i].nd != 0) begin
        send_byte({6'b0, VECS[i].dat[9:8]}, 1'b0, VECS[i].rd);
        send_byte(VECS[i].dat[7:0], 1'b0, VECS[i].rd);
      end
      send_stop();
      check(vreq(i), wiper_pos, VECS[i].exp_wip);
      check(vreq(i), busy, VECS[i].exp_busy);
      wait_idle();
      wp_n = 1;
    end

    // R8 truncated wiper write
    send_byte(8'hA0, 1'b1, 1'b0);
    send_byte(8'h02, 1'b0, 1'b0);
    send_stop();
    check("R8", wiper_pos, 10'h001);
    check("R8", busy, 0);
    // R8 truncated data-register write, then read register 1 back
    send_byte(8'hC4, 1'b1, 1'b0);
    send_byte(8'h03, 1'b0, 1'b0);
    send_stop();
    check("R8", busy, 0);
    send_byte(8'hA4, 1'b1, 1'b1);
    recv_byte(b0); recv_byte(b1);
    send_stop();
    check("R8", {b0, b1}, 16'h0123);

    // R5 busy length, R10 ready low and offered bytes dropped
    send_byte(8'hC0, 1'b1, 1'b0);
    send_byte(8'h00, 1'b0, 1'b0);
    send_byte(8'h5A, 1'b0, 1'b0);
    send_stop();
    in_valid = 1; in_first = 1; in_rd = 0; in_byte = 8'hA0;
    cnt = 0;
    while (busy) begin
      cnt++;
      if (in_ready) check("R10", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 0; in_first = 0;
    check("R5", cnt, BUSY_N);
    send_stop();
    check("R10", wiper_pos, 10'h001);
    send_byte(8'hA0, 1'b1, 1'b1);
    recv_byte(b0); recv_byte(b1);
    send_stop();
    check("R5", {b0, b1}, 16'h005A);

    // R4 back-pressure holds the first read byte
    send_byte(8'hA4, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R4", {out_valid, out_byte}, {1'b1, 8'h01});
    end
    recv_byte(b0); recv_byte(b1);
    check("R4", b1, 8'h23);
    send_stop();
    check("R11", wiper_pos, 10'h001);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule